// File: doc/BRIEF.md
# Service Test-Tone Mode Sequencer

This block walks a service technician through the diagnostic mode of an audio processor front panel, once that mode has been entered. It takes single-cycle strobes from four debounced panel keys (power, input, effect, output) and moves through three stages. The first is an indicator check: a lamp walks across the panel, then every lamp and the infrared emitters are lit, then everything is dark. The second is a key check, in which each key lights its own indicator group. The third is a tone stage that selects one of four fixed test tones and routes it to both channels, the left channel only or the right channel only.

In every stage the block drives a 16-bit indicator pattern that tells the technician which step is active. In the tone stage it also drives a 2-bit tone selector and a 2-bit channel-enable pair for the tone generator and mute logic further down the path. When the technician leaves the tone stage, a sticky done flag tells the panel controller to continue into normal power-on operation. All outputs are decoded from registered state, so an output moves on the clock edge that samples the key strobe.

Top module: `tt_test_sequencer`

## Requirements
- R1: The block leaves reset in the indicator-walk stage. In that state `led_o` is 16'h0001, and `ir_on_o`, `tone_on_o`, `done_o`, `tone_sel_o` and `ch_en_o` are all zero.
- R2: During the walk exactly one `led_o` bit is lit. The lit position moves up by one every SEQ_DIV clocks, from bit 0 to bit 15, and then wraps to bit 0.
- R3: EFFECT in the walk lights all sixteen bits (16'hFFFF) and sets `ir_on_o`. A second EFFECT clears `led_o` to zero and clears `ir_on_o`. Further EFFECT presses in the dark state are ignored.
- R4: POWER is acted on only in the dark state. It moves the block to the key check with `led_o` = 16'h0001. POWER during the walk or the all-lit state is ignored.
- R5: In the key check, INPUT shows 16'h000E, EFFECT shows 16'h0070 and OUTPUT shows 16'hFF80. Each press replaces the previous pattern.
- R6: POWER in the key check enters the tone stage at step 0 with both channels on: `tone_on_o`=1, `tone_sel_o`=0, `ch_en_o`=2'b11.
- R7: `tone_sel_o` codes are 0 = 1 kHz at 0 dBV, 1 = 1 kHz at -10 dBV, 2 = 100 Hz at -10 dBV, 3 = 10 kHz at -10 dBV. INPUT advances one step, and step 3 wraps to step 0.
- R8: In the tone stage `led_o` holds the channel lamps (bits 7, 9, 14, 15 = 16'hC280 with both channels on) ORed with a step mark. The mark is bit 1 for step 0, bit 2 for step 1, bits 3 and 8 for step 2, and bit 4 for step 3.
- R9: OUTPUT in the tone stage rotates `ch_en_o` (bit 0 = left, bit 1 = right) from 2'b11 to 2'b01 to 2'b10 and back to 2'b11. Bit 15 is dropped from the channel lamps for left-only, and bit 14 is dropped for right-only.
- R10: Each move to a new tone step, including the wrap, returns `ch_en_o` to 2'b11.
- R11: POWER in the tone stage sets `done_o`, which stays set. From then on `led_o`, `ir_on_o`, `tone_on_o`, `tone_sel_o` and `ch_en_o` are zero and every key is ignored.
- R12: When several strobes arrive in one cycle, only the highest-priority one is considered: POWER, then INPUT, then EFFECT, then OUTPUT. This holds even when that key has no effect in the current stage.
- R13: INPUT and OUTPUT have no effect in any indicator-check state, and EFFECT has no effect in the tone stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| key_power_i | input | 1 | POWER key strobe, one cycle |
| key_input_i | input | 1 | INPUT key strobe, one cycle |
| key_effect_i | input | 1 | EFFECT key strobe, one cycle |
| key_output_i | input | 1 | OUTPUT key strobe, one cycle |
| led_o | output | 16 | Indicator pattern |
| ir_on_o | output | 1 | Infrared emitters lit |
| tone_on_o | output | 1 | Tone stage active |
| tone_sel_o | output | 2 | Tone step code |
| ch_en_o | output | 2 | Channel enables, bit 0 left, bit 1 right |
| done_o | output | 1 | Test mode finished, continue to normal power-on |

## Verification
The bench builds the block with SEQ_DIV set to 3, so the walking lamp covers all sixteen positions and wraps within about fifty clocks. This puts the walk, the wrap and every later stage into one short run. The four tone steps and three channel states are fixed by the block's function, so the tone wrap and each rotation state are reached at the default sizes. Simultaneous-strobe cases are driven in the walk, the key check and the tone stage, so that priority is seen both where the winning key acts and where it is ignored.

// File: rtl/tt_pkg.sv
// Package: shared types and fixed indicator layout for the test-tone sequencer.
// Assumes a 16-lamp panel; bit positions are decoded by the panel driver.
package tt_pkg;

    localparam int LED_W     = 16;
    localparam int NUM_KEYS  = 4;
    localparam int NUM_TONES = 4;

    // Lamp positions on the panel driver chain
    localparam int LB_PWR   = 0;
    localparam int LB_SRC1  = 1;
    localparam int LB_SRC2  = 2;
    localparam int LB_LINE  = 3;
    localparam int LB_FX1   = 4;
    localparam int LB_FX2   = 5;
    localparam int LB_FX3   = 6;
    localparam int LB_L     = 7;
    localparam int LB_C     = 8;
    localparam int LB_R     = 9;
    localparam int LB_LS    = 10;
    localparam int LB_RS    = 11;
    localparam int LB_CS    = 12;
    localparam int LB_VIRT  = 13;
    localparam int LB_HL    = 14;
    localparam int LB_HR    = 15;

    // Key index order is also the priority order (0 wins)
    localparam int K_PWR = 0;
    localparam int K_INP = 1;
    localparam int K_EFF = 2;
    localparam int K_OUT = 3;

    typedef enum logic [2:0] {
        ST_WALK   = 3'd0,
        ST_ALLON  = 3'd1,
        ST_ALLOFF = 3'd2,
        ST_KEYCHK = 3'd3,
        ST_TONE   = 3'd4,
        ST_DONE   = 3'd5
    } tt_stage_e;

    typedef enum logic [1:0] {
        ROT_BOTH  = 2'd0,
        ROT_LEFT  = 2'd1,
        ROT_RIGHT = 2'd2
    } tt_rot_e;

    typedef enum logic [1:0] {
        KG_POWER  = 2'd0,
        KG_INPUT  = 2'd1,
        KG_EFFECT = 2'd2,
        KG_OUTPUT = 2'd3
    } tt_kgrp_e;

    typedef struct packed {
        logic pwr;
        logic inp;
        logic eff;
        logic outk;
    } tt_evt_t;

    function automatic logic [LED_W-1:0] lamp(input int pos);
        logic [LED_W-1:0] v;
        v = '0;
        v[pos] = 1'b1;
        return v;
    endfunction

    // Indicator group lit by each key during the key check
    function automatic logic [LED_W-1:0] group_mask(input tt_kgrp_e g);
        case (g)
            KG_INPUT:  return lamp(LB_SRC1) | lamp(LB_SRC2) | lamp(LB_LINE);
            KG_EFFECT: return lamp(LB_FX1) | lamp(LB_FX2) | lamp(LB_FX3);
            KG_OUTPUT: return lamp(LB_L) | lamp(LB_C) | lamp(LB_R) | lamp(LB_LS)
                            | lamp(LB_RS) | lamp(LB_CS) | lamp(LB_VIRT)
                            | lamp(LB_HL) | lamp(LB_HR);
            default:   return lamp(LB_PWR);
        endcase
    endfunction

    // Step mark shown beside the channel lamps in the tone stage
    function automatic logic [LED_W-1:0] step_mark(input logic [1:0] idx);
        case (idx)
            2'd0:    return lamp(LB_SRC1);
            2'd1:    return lamp(LB_SRC2);
            2'd2:    return lamp(LB_LINE) | lamp(LB_C);
            default: return lamp(LB_FX1) | lamp(LB_R);
        endcase
    endfunction

    // Channel lamps for each rotation state
    function automatic logic [LED_W-1:0] chan_lamps(input tt_rot_e r);
        logic [LED_W-1:0] v;
        v = lamp(LB_L) | lamp(LB_R) | lamp(LB_HL) | lamp(LB_HR);
        case (r)
            ROT_LEFT:  v[LB_HR] = 1'b0;
            ROT_RIGHT: v[LB_HL] = 1'b0;
            default:   v = v;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/tt_key_arb.sv
// Module: fixed-priority selector over the key strobes.
// Assumes strobes are already debounced single-cycle pulses; index 0 wins.
module tt_key_arb
    import tt_pkg::*;
#(
    parameter int N = NUM_KEYS
) (
    input  logic [N-1:0] req_i,
    output logic [N-1:0] gnt_o
);

    logic [N:0] seen;

    // Chain of "a higher-priority key is present" flags
    assign seen[0] = 1'b0;

    generate
        for (genvar i = 0; i < N; i++) begin : g_prio
            assign seen[i+1] = seen[i] | req_i[i];
            assign gnt_o[i]  = req_i[i] & ~seen[i];
        end
    endgenerate

endmodule

// File: rtl/tt_walker.sv
// Module: walking-lamp position for the first indicator check.
// Assumes en_i is high only in the walk stage; position clears when low.
module tt_walker #(
    parameter int SEQ_DIV = 50_000_000,
    parameter int LED_W   = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en_i,
    output logic [$clog2(LED_W)-1:0] pos_o
);

    localparam int CW = (SEQ_DIV > 1) ? $clog2(SEQ_DIV) : 1;
    localparam int PW = $clog2(LED_W);

    logic [CW-1:0] div_q;
    logic          tick;

    assign tick = (div_q == CW'(SEQ_DIV - 1));

    // Prescaler that paces the walk
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            div_q <= '0;
        end else if (tick) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    // Lamp position, wrapping after the last lamp
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            pos_o <= '0;
        end else if (tick) begin
            pos_o <= (pos_o == PW'(LED_W - 1)) ? '0 : pos_o + 1'b1;
        end
    end

    AST_WALK_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && $past(en_i) && !$past(tick)) |-> $stable(pos_o)); // R2

endmodule

// File: rtl/tt_stage_fsm.sv
// Module: stage, tone step and channel rotation state.
// Assumes at most one event bit is set per cycle (arbiter upstream).
module tt_stage_fsm
    import tt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  tt_evt_t    evt_i,
    output tt_stage_e  stage_o,
    output logic [1:0] tone_o,
    output tt_rot_e    rot_o,
    output tt_kgrp_e   kgrp_o
);

    localparam logic [1:0] LAST_TONE = 2'(NUM_TONES - 1);

    function automatic tt_rot_e rot_next(input tt_rot_e r);
        case (r)
            ROT_BOTH: return ROT_LEFT;
            ROT_LEFT: return ROT_RIGHT;
            default:  return ROT_BOTH;
        endcase
    endfunction

    // Stage transitions and per-stage state updates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_o <= ST_WALK;
            tone_o  <= '0;
            rot_o   <= ROT_BOTH;
            kgrp_o  <= KG_POWER;
        end else begin
            case (stage_o)
                ST_WALK: begin
                    if (evt_i.eff) stage_o <= ST_ALLON;
                end
                ST_ALLON: begin
                    if (evt_i.eff) stage_o <= ST_ALLOFF;
                end
                ST_ALLOFF: begin
                    if (evt_i.pwr) begin
                        stage_o <= ST_KEYCHK;
                        kgrp_o  <= KG_POWER;
                    end
                end
                ST_KEYCHK: begin
                    if (evt_i.pwr) begin
                        stage_o <= ST_TONE;
                        tone_o  <= '0;
                        rot_o   <= ROT_BOTH;
                    end else if (evt_i.inp) begin
                        kgrp_o <= KG_INPUT;
                    end else if (evt_i.eff) begin
                        kgrp_o <= KG_EFFECT;
                    end else if (evt_i.outk) begin
                        kgrp_o <= KG_OUTPUT;
                    end
                end
                ST_TONE: begin
                    if (evt_i.pwr) begin
                        stage_o <= ST_DONE;
                    end else if (evt_i.inp) begin
                        tone_o <= (tone_o == LAST_TONE) ? '0 : tone_o + 2'd1;
                        rot_o  <= ROT_BOTH;
                    end else if (evt_i.outk) begin
                        rot_o <= rot_next(rot_o);
                    end
                end
                ST_DONE: begin
                    stage_o <= ST_DONE;
                end
                default: stage_o <= ST_WALK;
            endcase
        end
    end

    AST_TONE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_o == ST_TONE && evt_i.inp && !evt_i.pwr && tone_o == LAST_TONE)
        |=> tone_o == 2'd0); // R7

    AST_ROT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_o == ST_TONE && evt_i.inp && !evt_i.pwr) |=> rot_o == ROT_BOTH); // R10

    AST_PWR_EARLY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        ((stage_o == ST_WALK || stage_o == ST_ALLON) && evt_i.pwr)
        |=> stage_o != ST_KEYCHK); // R4

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_o == ST_DONE) |=> (stage_o == ST_DONE)); // R11

endmodule

// File: rtl/tt_out_decode.sv
// Module: turns registered state into indicator, emitter and tone outputs.
// Assumes inputs come straight from flops; purely combinational.
module tt_out_decode
    import tt_pkg::*;
(
    input  tt_stage_e                stage_i,
    input  logic [$clog2(LED_W)-1:0] pos_i,
    input  logic [1:0]               tone_i,
    input  tt_rot_e                  rot_i,
    input  tt_kgrp_e                 kgrp_i,
    output logic [LED_W-1:0]         led_o,
    output logic                     ir_on_o,
    output logic                     tone_on_o,
    output logic [1:0]               tone_sel_o,
    output logic [1:0]               ch_en_o,
    output logic                     done_o
);

    // Per-stage output selection
    always_comb begin
        led_o      = '0;
        ir_on_o    = 1'b0;
        tone_on_o  = 1'b0;
        tone_sel_o = '0;
        ch_en_o    = '0;
        done_o     = 1'b0;
        case (stage_i)
            ST_WALK:   led_o = LED_W'(1) << pos_i;
            ST_ALLON: begin
                led_o   = '1;
                ir_on_o = 1'b1;
            end
            ST_KEYCHK: led_o = group_mask(kgrp_i);
            ST_TONE: begin
                led_o      = chan_lamps(rot_i) | step_mark(tone_i);
                tone_on_o  = 1'b1;
                tone_sel_o = tone_i;
                case (rot_i)
                    ROT_LEFT:  ch_en_o = 2'b01;
                    ROT_RIGHT: ch_en_o = 2'b10;
                    default:   ch_en_o = 2'b11;
                endcase
            end
            ST_DONE:   done_o = 1'b1;
            default:   led_o = '0;
        endcase
    end

endmodule

// File: rtl/tt_test_sequencer.sv
// Module: top of the service test-tone sequencer.
// Assumes it is released from reset when test mode has been entered and that
// key strobes are debounced one-cycle pulses in the clk domain.
module tt_test_sequencer
    import tt_pkg::*;
#(
    parameter int SEQ_DIV = 50_000_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        key_power_i,
    input  logic        key_input_i,
    input  logic        key_effect_i,
    input  logic        key_output_i,
    output logic [15:0] led_o,
    output logic        ir_on_o,
    output logic        tone_on_o,
    output logic [1:0]  tone_sel_o,
    output logic [1:0]  ch_en_o,
    output logic        done_o
);

    localparam int PW = $clog2(LED_W);

    logic [NUM_KEYS-1:0] req;
    logic [NUM_KEYS-1:0] gnt;
    tt_evt_t             evt;
    tt_stage_e           stage;
    logic [1:0]          tone;
    tt_rot_e             rot;
    tt_kgrp_e            kgrp;
    logic [PW-1:0]       pos;

    // Gather strobes in priority order
    always_comb begin
        req        = '0;
        req[K_PWR] = key_power_i;
        req[K_INP] = key_input_i;
        req[K_EFF] = key_effect_i;
        req[K_OUT] = key_output_i;
    end

    tt_key_arb #(.N(NUM_KEYS)) arb_i (
        .req_i (req),
        .gnt_o (gnt)
    );

    // Map the granted key onto the event struct
    always_comb begin
        evt.pwr  = gnt[K_PWR];
        evt.inp  = gnt[K_INP];
        evt.eff  = gnt[K_EFF];
        evt.outk = gnt[K_OUT];
    end

    tt_stage_fsm fsm_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_i   (evt),
        .stage_o (stage),
        .tone_o  (tone),
        .rot_o   (rot),
        .kgrp_o  (kgrp)
    );

    tt_walker #(.SEQ_DIV(SEQ_DIV), .LED_W(LED_W)) walk_i (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (stage == ST_WALK),
        .pos_o (pos)
    );

    tt_out_decode dec_i (
        .stage_i    (stage),
        .pos_i      (pos),
        .tone_i     (tone),
        .rot_i      (rot),
        .kgrp_i     (kgrp),
        .led_o      (led_o),
        .ir_on_o    (ir_on_o),
        .tone_on_o  (tone_on_o),
        .tone_sel_o (tone_sel_o),
        .ch_en_o    (ch_en_o),
        .done_o     (done_o)
    );

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt)); // R12

    AST_TONE_CHAN_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        tone_on_o |-> (ch_en_o != 2'b00)); // R9

    AST_DONE_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (led_o == '0 && !tone_on_o && ch_en_o == 2'b00 && !ir_on_o)); // R11

    AST_WALK_ONE_LAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (stage == ST_WALK) |-> ($countones(led_o) == 1)); // R2

endmodule

// File: tb/tt_test_sequencer_tb.sv
// Bench: behavioural reference compared on every falling edge, plus directed checks.
module tt_test_sequencer_tb_top;

    localparam int DIV = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        kp = 1'b0, ki = 1'b0, ke = 1'b0, ko = 1'b0;
    logic [15:0] led;
    logic        ir, ton, dn;
    logic [1:0]  tsel, chen;

    int    n_chk = 0;
    int    n_err = 0;
    int    cyc = 0;
    bit    ended = 0;
    string cur_req = "R1";

    // Reference state: 0 walk, 1 all-on, 2 all-off, 3 key check, 4 tone, 5 done
    int m_stage, m_div, m_pos, m_grp, m_tone, m_rot;

    always #2 clk = ~clk;

    tt_test_sequencer #(.SEQ_DIV(DIV)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .key_power_i  (kp),
        .key_input_i  (ki),
        .key_effect_i (ke),
        .key_output_i (ko),
        .led_o        (led),
        .ir_on_o      (ir),
        .tone_on_o    (ton),
        .tone_sel_o   (tsel),
        .ch_en_o      (chen),
        .done_o       (dn)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Reference update on each rising edge
    always @(posedge clk) begin
        int key;
        if (!rst_n) begin
            m_stage = 0; m_div = 0; m_pos = 0; m_grp = 0; m_tone = 0; m_rot = 0;
        end else begin
            key = kp ? 0 : ki ? 1 : ke ? 2 : ko ? 3 : -1;
            if (m_stage == 0) begin
                if (m_div == DIV - 1) begin m_div = 0; m_pos = (m_pos + 1) % 16; end
                else m_div++;
            end else begin
                m_div = 0; m_pos = 0;
            end
            case (m_stage)
                0: if (key == 2) m_stage = 1;
                1: if (key == 2) m_stage = 2;
                2: if (key == 0) begin m_stage = 3; m_grp = 0; end
                3: if (key == 0) begin m_stage = 4; m_tone = 0; m_rot = 0; end
                   else if (key > 0) m_grp = key;
                4: if (key == 0) m_stage = 5;
                   else if (key == 1) begin m_tone = (m_tone + 1) % 4; m_rot = 0; end
                   else if (key == 3) m_rot = (m_rot + 1) % 3;
                default: ;
            endcase
        end
    end

    function automatic int exp_led();
        int v;
        case (m_stage)
            0: return 1 << m_pos;
            1: return 'hFFFF;
            3: case (m_grp) 1: return 'h000E; 2: return 'h0070; 3: return 'hFF80; default: return 'h0001; endcase
            4: begin
                v = (m_rot == 1) ? 'h4280 : (m_rot == 2) ? 'h8280 : 'hC280;
                case (m_tone) 0: v |= 'h0002; 1: v |= 'h0004; 2: v |= 'h0108; default: v |= 'h0210; endcase
                return v;
            end
            default: return 0;
        endcase
    endfunction

    // Compare against the reference away from the active edge
    always @(negedge clk) begin
        if (rst_n && !ended) begin
            chk(cur_req, "led", led, exp_led());
            chk(cur_req, "ir", ir, m_stage == 1);
            chk(cur_req, "tone_on", ton, m_stage == 4);
            chk(cur_req, "tone_sel", tsel, (m_stage == 4) ? m_tone : 0);
            chk(cur_req, "ch_en", chen, (m_stage != 4) ? 0 : (m_rot == 1) ? 1 : (m_rot == 2) ? 2 : 3);
            chk(cur_req, "done", dn, m_stage == 5);
        end
    end

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_err++; n_chk++;
            $display("FAIL watchdog actual=%0d expected<20000", cyc);
            finish_run();
        end
    end

    // k[0] POWER, k[1] INPUT, k[2] EFFECT, k[3] OUTPUT
    task automatic press(input logic [3:0] k, input string tag);
        @(negedge clk);
        cur_req = tag;
        {ko, ke, ki, kp} = k;
        @(negedge clk);
        {ko, ke, ki, kp} = 4'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state seen one clock after release (walk moved 0 of DIV)
        chk("R1", "led after reset", led, 'h0001);
        chk("R1", "done after reset", dn, 0);
        cur_req = "R2";
        repeat (16 * DIV + 7) @(negedge clk);
        press(4'b1000, "R13");
        press(4'b0010, "R13");
        press(4'b0001, "R4");
        press(4'b0101, "R12");
        press(4'b0100, "R3");
        chk("R3", "all lamps", led, 'hFFFF);
        chk("R3", "emitters", ir, 1);
        press(4'b0001, "R4");
        chk("R4", "power ignored while lit", led, 'hFFFF);
        press(4'b0010, "R13");
        press(4'b0100, "R3");
        chk("R3", "all dark", led, 0);
        press(4'b0100, "R3");
        press(4'b0001, "R4");
        chk("R4", "key check entry", led, 'h0001);
        press(4'b0010, "R5");
        chk("R5", "input group", led, 'h000E);
        press(4'b0100, "R5");
        press(4'b1000, "R5");
        chk("R5", "output group", led, 'hFF80);
        press(4'b0110, "R12");
        chk("R12", "input beats effect", led, 'h000E);
        press(4'b0001, "R6");
        chk("R6", "tone entry ch", chen, 3);
        chk("R8", "step0 lamps", led, 'hC282);
        press(4'b1000, "R9");
        chk("R9", "left only", chen, 1);
        press(4'b1000, "R9");
        chk("R9", "right only", chen, 2);
        press(4'b1000, "R9");
        press(4'b1000, "R9");
        press(4'b0010, "R10");
        chk("R10", "rotation restart", chen, 3);
        press(4'b0010, "R7");
        chk("R8", "step2 lamps", led, 'hC388);
        press(4'b0010, "R7");
        press(4'b1000, "R8");
        press(4'b0010, "R7");
        chk("R7", "wrap to step0", tsel, 0);
        press(4'b0100, "R13");
        press(4'b1010, "R12");
        chk("R12", "input beats output", tsel, 1);
        press(4'b0011, "R11");
        chk("R11", "done set", dn, 1);
        press(4'b0010, "R11");
        press(4'b1000, "R11");
        press(4'b0001, "R11");
        chk("R11", "dark after done", led, 0);
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule